// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block sits beside one port of a storage host controller. It holds the port's pending-command bitmap, which host writes fill bit by bit, and it hands the pending slots to a downstream command engine one at a time. Each cycle it looks for the lowest pending slot at or above its scan pointer. When the engine is idle, it raises a dispatch strobe carrying that slot number.

The engine answers in the dispatch cycle on `disp_async`. A low answer means the command finished at once: the slot's pending bit is cleared on the same edge, a clear strobe reports it, and scanning starts again from slot 0. A high answer means the engine stays busy or requests data. The slot is then parked as the single outstanding slot and its bit stays set. No further dispatch happens until both engine status lines fall. At that point the parked slot is retired, with a clear strobe, and scanning resumes from slot 0. A port reset input empties the bitmap, the parked marker and the scan pointer.

Top module: `slot_issue_sched`

## Requirements
- R1: No dispatch strobe is raised while `start_en` is low or while no pending bit is set. Pending bits are kept meanwhile.
- R2: Pending slots are dispatched lowest index first, with at most one dispatch per cycle. After every retirement the scan restarts at slot 0.
- R3: While `eng_busy` or `eng_drq` is high, no dispatch takes place and the pending bit stays set. The same slot is offered again in the first cycle both lines are low.
- R4: A dispatch answered with `disp_async` = 0 raises `clr_vld` in the same cycle, with `clr_slot` equal to `disp_slot`. The pending bit reads 0 after the next edge.
- R5: A dispatch answered with `disp_async` = 1 parks the slot and leaves its pending bit set. No dispatch and no clear happen while a slot is parked and the engine shows busy or data request.
- R6: While a slot is parked, the first cycle with both `eng_busy` and `eng_drq` low raises `clr_vld` with the parked slot number. The bit is then cleared, the marker becomes empty, and the next pending slot may dispatch in the following cycle.
- R7: A host write (`host_wr_en` = 1) ORs `host_wr_data` into the bitmap (bit n = slot n). Zero bits in the write clear nothing.
- R8: If a host write sets the bit of the slot being cleared in the same cycle, the write wins and the slot stays pending.
- R9: While `port_rst` is high, the bitmap, the parked marker and the scan pointer are emptied on the next edge. Strobes are held low, and a host write in that cycle is discarded.
- R10: After `rst_n` is released, the bitmap reads 0 and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_rst | input | 1 | Synchronous port reset |
| start_en | input | 1 | Port command processing enabled |
| host_wr_en | input | 1 | Host write to the pending bitmap |
| host_wr_data | input | NUM_SLOTS | Bits to set |
| eng_busy | input | 1 | Engine busy status |
| eng_drq | input | 1 | Engine data-request status |
| disp_async | input | 1 | Engine answer in the dispatch cycle: 1 = continues asynchronously |
| disp_vld | output | 1 | Dispatch strobe |
| disp_slot | output | IDX_W | Dispatched slot number |
| clr_vld | output | 1 | Pending-bit clear strobe |
| clr_slot | output | IDX_W | Slot whose bit is cleared |
| issue_pend | output | NUM_SLOTS | Current pending bitmap |

## Verification
Two functions can fall in the same cycle: a host write and the retirement of a slot, whether that retirement is synchronous or a parked one. The bench parks a slot. It then drops the engine status in the very cycle it writes a mask that re-sets that slot and adds a lower one. It judges the outcome by the clear strobe naming the parked slot, the bitmap afterwards holding both bits, and the two slots then dispatching in ascending order. A port reset that coincides with a host write and a parked slot is provoked the same way: the written bit must be lost, and no retirement strobe may follow.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

  // kind of scheduling event taken in a cycle
  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_REFUSE = 3'd1,
    EV_SYNC   = 3'd2,
    EV_PARK   = 3'd3,
    EV_RETIRE = 3'd4
  } sched_ev_e;

  function automatic sched_ev_e classify_ev(input logic refuse, input logic dispatch,
                                            input logic async, input logic retire);
    if (retire)        return EV_RETIRE;
    else if (dispatch) return async ? EV_PARK : EV_SYNC;
    else if (refuse)   return EV_REFUSE;
    else               return EV_NONE;
  endfunction

endpackage

// File: rtl/issue_bitmap.sv
module issue_bitmap #(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 port_rst,
  input  logic                 set_en,
  input  logic [NUM_SLOTS-1:0] set_bits,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  output logic [NUM_SLOTS-1:0] bits
);

  logic [NUM_SLOTS-1:0] clr_mask;
  logic [NUM_SLOTS-1:0] bits_nxt;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
    // a write in the same cycle wins over the clear
    bits_nxt = (bits & ~clr_mask) | (set_en ? set_bits : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bits <= '0;
    else if (port_rst) bits <= '0;
    else               bits <= bits_nxt;
  end

endmodule

// File: rtl/slot_picker.sv
module slot_picker #(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] vec,
  input  logic [IDX_W-1:0]     from_idx,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);

  // lowest set bit whose index is not below the start point
  function automatic logic [IDX_W:0] first_from(input logic [NUM_SLOTS-1:0] v,
                                                input logic [IDX_W-1:0] start);
    logic [IDX_W:0] res;
    res = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (v[i] && (i >= int'(start))) res = {1'b1, IDX_W'(i)};
    end
    return res;
  endfunction

  logic [IDX_W:0] found;

  assign found = first_from(vec, from_idx);
  assign hit   = found[IDX_W];
  assign idx   = found[IDX_W-1:0];

endmodule

// File: rtl/busy_tracker.sv
module busy_tracker #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_rst,
  input  logic             park_en,
  input  logic [IDX_W-1:0] park_idx_in,
  input  logic             release_en,
  output logic             vld,
  output logic [IDX_W-1:0] idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      idx <= '0;
    end else if (port_rst || release_en) begin
      vld <= 1'b0;
      idx <= '0;
    end else if (park_en) begin
      vld <= 1'b1;
      idx <= park_idx_in;
    end
  end

endmodule

// File: rtl/slot_issue_sched.sv
module slot_issue_sched #(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 port_rst,
  input  logic                 start_en,
  input  logic                 host_wr_en,
  input  logic [NUM_SLOTS-1:0] host_wr_data,
  input  logic                 eng_busy,
  input  logic                 eng_drq,
  input  logic                 disp_async,
  output logic                 disp_vld,
  output logic [IDX_W-1:0]     disp_slot,
  output logic                 clr_vld,
  output logic [IDX_W-1:0]     clr_slot,
  output logic [NUM_SLOTS-1:0] issue_pend
);
  import slot_sched_pkg::*;

  logic [IDX_W-1:0] scan_ptr;
  logic             pick_hit;
  logic [IDX_W-1:0] pick_idx;
  logic             park_vld;
  logic [IDX_W-1:0] park_idx;
  logic             eng_idle;
  logic             scan_ok;

  // named internal events
  logic      ev_dispatch;
  logic      ev_refuse;
  logic      ev_sync;
  logic      ev_park;
  logic      ev_retire;
  sched_ev_e ev_kind;

  assign eng_idle    = !eng_busy && !eng_drq;
  assign scan_ok     = start_en && (|issue_pend) && !park_vld && !port_rst;
  assign ev_dispatch = scan_ok && pick_hit && eng_idle;
  assign ev_refuse   = scan_ok && pick_hit && !eng_idle;
  assign ev_sync     = ev_dispatch && !disp_async;
  assign ev_park     = ev_dispatch && disp_async;
  assign ev_retire   = park_vld && eng_idle && !port_rst;
  assign ev_kind     = classify_ev(ev_refuse, ev_dispatch, disp_async, ev_retire);

  assign disp_vld  = ev_dispatch;
  assign disp_slot = pick_idx;
  assign clr_vld   = ev_sync || ev_retire;
  assign clr_slot  = ev_retire ? park_idx : pick_idx;

  issue_bitmap #(.NUM_SLOTS(NUM_SLOTS)) u_bitmap (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_rst (port_rst),
    .set_en   (host_wr_en),
    .set_bits (host_wr_data),
    .clr_en   (clr_vld),
    .clr_idx  (clr_slot),
    .bits     (issue_pend)
  );

  slot_picker #(.NUM_SLOTS(NUM_SLOTS)) u_picker (
    .vec      (issue_pend),
    .from_idx (scan_ptr),
    .hit      (pick_hit),
    .idx      (pick_idx)
  );

  busy_tracker #(.IDX_W(IDX_W)) u_busy (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_rst    (port_rst),
    .park_en     (ev_park),
    .park_idx_in (pick_idx),
    .release_en  (ev_retire),
    .vld         (park_vld),
    .idx         (park_idx)
  );

  // scan pointer: restart at 0 after a retirement or an empty pass,
  // stay on a refused slot so it is retried first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_ptr <= '0;
    end else begin
      unique case (ev_kind)
        EV_SYNC, EV_RETIRE: scan_ptr <= '0;
        EV_PARK, EV_REFUSE: scan_ptr <= pick_idx;
        default: begin
          if (port_rst || !(|issue_pend) || (scan_ok && !pick_hit)) scan_ptr <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         port_rst,
  input logic                         start_en,
  input logic                         host_wr_en,
  input logic [NUM_SLOTS-1:0]         host_wr_data,
  input logic                         eng_busy,
  input logic                         eng_drq,
  input logic                         disp_vld,
  input logic [IDX_W-1:0]             disp_slot,
  input logic                         disp_async,
  input logic                         clr_vld,
  input logic [IDX_W-1:0]             clr_slot,
  input logic [NUM_SLOTS-1:0]         issue_pend,
  input logic                         park_vld,
  input logic [IDX_W-1:0]             park_idx,
  input slot_sched_pkg::sched_ev_e    ev_kind
);
  import slot_sched_pkg::*;

  a_r1_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_en || issue_pend == '0) |-> !disp_vld);

  a_r2_dispatch_pending: assert property (@(posedge clk) disable iff (!rst_n)
    disp_vld |-> issue_pend[disp_slot]);

  a_r3_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy || eng_drq) |-> !disp_vld);

  a_r4_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld && !disp_async && !port_rst && !(host_wr_en && host_wr_data[disp_slot]))
      |=> !issue_pend[$past(disp_slot)]);

  a_r5_park_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kind == EV_PARK) |=> (park_vld && issue_pend[$past(disp_slot)]));

  a_r5_parked_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    park_vld |-> !disp_vld);

  a_r6_retire_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (park_vld && !eng_busy && !eng_drq && !port_rst) |-> (clr_vld && clr_slot == park_idx));

  a_r6_marker_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kind == EV_RETIRE) |=> !park_vld);

  a_r7_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && !port_rst) |=> ((issue_pend & $past(host_wr_data)) == $past(host_wr_data)));

  a_r8_write_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && host_wr_en && host_wr_data[clr_slot] && !port_rst) |=> issue_pend[$past(clr_slot)]);

  a_r9_port_reset: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst |=> (issue_pend == '0 && !park_vld));

endmodule

bind slot_issue_sched slot_sched_chk #(.NUM_SLOTS(NUM_SLOTS)) u_sched_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .port_rst     (port_rst),
  .start_en     (start_en),
  .host_wr_en   (host_wr_en),
  .host_wr_data (host_wr_data),
  .eng_busy     (eng_busy),
  .eng_drq      (eng_drq),
  .disp_vld     (disp_vld),
  .disp_slot    (disp_slot),
  .disp_async   (disp_async),
  .clr_vld      (clr_vld),
  .clr_slot     (clr_slot),
  .issue_pend   (issue_pend),
  .park_vld     (park_vld),
  .park_idx     (park_idx),
  .ev_kind      (ev_kind)
);

// File: tb/test_slot_issue_sched.sv
module test_slot_issue_sched;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_rst = 1'b0;
  logic        start_en = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic        eng_busy = 1'b0;
  logic        eng_drq = 1'b0;
  logic        disp_async = 1'b0;
  logic        disp_vld;
  logic [4:0]  disp_slot;
  logic        clr_vld;
  logic [4:0]  clr_slot;
  logic [31:0] issue_pend;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  slot_issue_sched i_slot_issue_sched (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .start_en(start_en),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .eng_busy(eng_busy), .eng_drq(eng_drq), .disp_async(disp_async),
    .disp_vld(disp_vld), .disp_slot(disp_slot),
    .clr_vld(clr_vld), .clr_slot(clr_slot), .issue_pend(issue_pend)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  // expect a dispatch of slot s; sync tells whether a clear goes with it
  task automatic exp_disp(input int s, input bit sync, input string req);
    chk(disp_vld == 1'b1, {req, " dispatch strobe"}, 32'(disp_vld), 1);
    chk(disp_slot == 5'(s), {req, " dispatch slot"}, 32'(disp_slot), 32'(s));
    chk(clr_vld == sync, {req, " clear with dispatch"}, 32'(clr_vld), 32'(sync));
    if (sync) chk(clr_slot == 5'(s), {req, " clear slot"}, 32'(clr_slot), 32'(s));
  endtask

  task automatic t_reset();
    step(); settle();
    chk(issue_pend == 32'h0, "R10 bitmap after reset", issue_pend, 0);
    chk(!disp_vld && !clr_vld, "R10 strobes after reset", {30'd0, disp_vld, clr_vld}, 0);
  endtask

  task automatic t_stopped();
    step(); host_wr_en = 1; host_wr_data = 32'h5;
    step(); host_wr_data = 32'h0;           // zero write: clears nothing
    step(); host_wr_en = 0;
    for (int k = 0; k < 3; k++) begin
      settle();
      chk(!disp_vld, "R1 no dispatch while start_en low", 32'(disp_vld), 0);
      step();
    end
    settle();
    chk(issue_pend == 32'h5, "R7 OR write, zero bits keep", issue_pend, 32'h5);
  endtask

  task automatic t_order_sync();
    int exp_s[4] = '{0, 2, 7, 20};
    start_en = 1; disp_async = 0;
    host_wr_en = 1; host_wr_data = 32'h0010_0080;
    settle();
    exp_disp(exp_s[0], 1, "R2 R4 ascending");
    step(); host_wr_en = 0;
    for (int k = 1; k < 4; k++) begin
      settle();
      exp_disp(exp_s[k], 1, "R2 R4 ascending");
      step();
    end
    settle();
    chk(issue_pend == 32'h0, "R4 all retired", issue_pend, 0);
    chk(!disp_vld, "R1 nothing pending", 32'(disp_vld), 0);
  endtask

  task automatic t_refuse();
    step(); eng_busy = 1; host_wr_en = 1; host_wr_data = 32'h10;
    step(); host_wr_en = 0;
    for (int k = 0; k < 3; k++) begin
      settle();
      chk(!disp_vld, "R3 refused while busy", 32'(disp_vld), 0);
      chk(issue_pend == 32'h10, "R3 bit kept", issue_pend, 32'h10);
      step();
    end
    eng_busy = 0; eng_drq = 1; settle();
    chk(!disp_vld, "R3 refused while drq", 32'(disp_vld), 0);
    step(); eng_drq = 0; settle();
    exp_disp(4, 1, "R3 retry when idle");
    step(); settle();
    chk(issue_pend == 32'h0, "R4 retried slot cleared", issue_pend, 0);
  endtask

  task automatic t_async();
    step(); disp_async = 1; host_wr_en = 1; host_wr_data = 32'h300;
    step(); host_wr_en = 0; settle();
    exp_disp(8, 0, "R5 async dispatch");
    step(); eng_busy = 1; disp_async = 0;
    for (int k = 0; k < 3; k++) begin
      settle();
      chk(issue_pend == 32'h300, "R5 parked bit kept", issue_pend, 32'h300);
      chk(!disp_vld && !clr_vld, "R5 no activity while parked", {30'd0, disp_vld, clr_vld}, 0);
      step();
    end
    eng_busy = 0; eng_drq = 1; settle();
    chk(!clr_vld, "R6 no retire while drq", 32'(clr_vld), 0);
    step(); eng_drq = 0; settle();
    chk(clr_vld && clr_slot == 5'd8, "R6 retire parked slot", {26'd0, clr_vld, clr_slot}, {26'd0, 1'b1, 5'd8});
    chk(!disp_vld, "R6 no dispatch in retire cycle", 32'(disp_vld), 0);
    step(); settle();
    chk(issue_pend == 32'h200, "R6 parked bit cleared", issue_pend, 32'h200);
    exp_disp(9, 1, "R6 R2 scan resumes");
    step(); settle();
    chk(issue_pend == 32'h0, "R4 empty after async run", issue_pend, 0);
  endtask

  task automatic t_collide();
    step(); disp_async = 1; host_wr_en = 1; host_wr_data = 32'h1000;
    step(); host_wr_en = 0; settle();
    exp_disp(12, 0, "R5 park slot 12");
    step(); eng_busy = 1; disp_async = 0; settle();
    chk(!clr_vld, "R5 no clear while busy", 32'(clr_vld), 0);
    step(); eng_busy = 0; host_wr_en = 1; host_wr_data = 32'h1002; settle();
    chk(clr_vld && clr_slot == 5'd12, "R8 retire with write", {26'd0, clr_vld, clr_slot}, {26'd0, 1'b1, 5'd12});
    step(); host_wr_en = 0; settle();
    chk(issue_pend == 32'h1002, "R8 write wins over clear", issue_pend, 32'h1002);
    exp_disp(1, 1, "R2 lowest first after collision");
    step(); settle();
    exp_disp(12, 1, "R8 reissued slot runs");
    step(); settle();
    chk(issue_pend == 32'h0, "R8 empty after collision", issue_pend, 0);
  endtask

  task automatic t_port_reset();
    step(); disp_async = 1; host_wr_en = 1; host_wr_data = 32'h8000_0001;
    step(); host_wr_en = 0; settle();
    exp_disp(0, 0, "R9 park before port reset");
    step(); eng_busy = 1; disp_async = 0;
    step(); port_rst = 1; host_wr_en = 1; host_wr_data = 32'h4; settle();
    chk(!disp_vld && !clr_vld, "R9 strobes low in port reset", {30'd0, disp_vld, clr_vld}, 0);
    step(); port_rst = 0; host_wr_en = 0; eng_busy = 0; settle();
    chk(issue_pend == 32'h0, "R9 bitmap emptied, write lost", issue_pend, 0);
    chk(!clr_vld, "R9 marker emptied", 32'(clr_vld), 0);
    step(); host_wr_en = 1; host_wr_data = 32'h40;
    step(); host_wr_en = 0; settle();
    exp_disp(6, 1, "R9 scan from start after port reset");
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_stopped();
    t_order_sync();
    t_refuse();
    t_async();
    t_collide();
    t_port_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule